// File: doc/BRIEF.md
# Posted-CAS Data Window Generator

This block sits between a memory controller's command scheduler and its data path. Each time the scheduler issues a read or write column command, the block works out when that burst's data will be on the bus. It then raises cycle-accurate enables for the data path: a read-capture window or a write-drive window, each bracketed by a strobe preamble enable and a strobe postamble enable. The timing follows a shadow copy of the mode settings: CAS latency, additive latency and a burst length of four or eight beats.

Read data begins additive plus CAS latency clocks after the command. Write data begins one clock earlier than that. A burst of four beats fills two clock cycles, and a burst of eight fills four. Latencies can exceed the command spacing, so each direction keeps a delay line of tokens and several commands can be in flight at once. When two bursts follow each other with no idle cycle between them, their windows join into one, with no preamble or postamble between them.

New settings arrive on a configuration strobe. They take effect only while nothing is in flight; otherwise they wait in a pending holding register.

Top module: `casw_window_gen`

## Requirements
- R1: After reset every enable output, `busy_o` and `cfg_pending_o` are low, and the settings are CAS latency 3, additive latency 0 and four-beat bursts.
- R2: A read command accepted in cycle t raises `rd_win_o` from cycle t+AL+CL for BL/2 consecutive cycles.
- R3: A write command accepted in cycle t raises `wr_win_o` from cycle t+AL+CL-1 for BL/2 consecutive cycles.
- R4: `cfg_bl8_i`=1 selects eight-beat bursts (4-cycle windows); 0 selects four-beat bursts (2-cycle windows).
- R5: A preamble enable is high in exactly the cycles in which its window is low and will be high in the next cycle.
- R6: A postamble enable is high in exactly the cycles in which its window is low and was high in the previous cycle.
- R7: Same-direction commands spaced exactly BL/2 cycles apart produce one continuous window, with no preamble or postamble between the bursts.
- R8: A configuration write whose CAS latency field (`cfg_cl_i`, binary clocks) is outside 3..6 or whose additive latency field (`cfg_al_i`, binary clocks) exceeds 5 is ignored entirely.
- R9: A legal configuration write is applied at the end of its cycle if nothing is in flight and no command is presented; otherwise it is held, `cfg_pending_o` is high from the next cycle, and it is applied at the end of the first cycle with nothing in flight and no command. Commands issued meanwhile use the old settings. A later legal write replaces a held one.
- R10: Commands of one direction spaced at least BL/2 cycles apart each produce their own window, even while earlier commands are still in flight.
- R11: `busy_o` is high from the cycle after a command is accepted through the cycle after its last window cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cl_i | input | 3 | Requested CAS latency in clocks |
| cfg_al_i | input | 3 | Requested additive latency in clocks |
| cfg_bl8_i | input | 1 | 1 = eight-beat burst, 0 = four-beat burst |
| cmd_valid_i | input | 1 | Column command accepted this cycle |
| cmd_write_i | input | 1 | 1 = write command, 0 = read command |
| rd_pre_o | output | 1 | Read strobe preamble enable |
| rd_win_o | output | 1 | Read data capture window |
| rd_post_o | output | 1 | Read strobe postamble enable |
| wr_pre_o | output | 1 | Write strobe preamble enable |
| wr_win_o | output | 1 | Write data drive window |
| wr_post_o | output | 1 | Write strobe postamble enable |
| busy_o | output | 1 | Some command still in flight |
| cfg_pending_o | output | 1 | A configuration write is being held |

## Verification
The bench aims at the shortest write latency of two clocks. A delay line indexed one place off would drop this token or move it by a cycle, and that shows at once on `wr_win_o`. Bursts spaced exactly BL/2 apart test the merge: a design that reloads its burst counter wrongly leaves a one-cycle hole, or raises a postamble and preamble inside the joined window. Configuration writes land while commands are in flight, while the delay lines drain, and with illegal field values. A design that applies them too early shifts the windows of bursts already in flight. One that applies illegal values mistimes every later window. Long random stretches that mix both directions at the largest latencies check that the two delay lines never disturb each other.

// File: rtl/casw_pkg.sv
package casw_pkg;
  localparam int unsigned CL_MIN = 3;
  localparam int unsigned CL_MAX = 6;
  localparam int unsigned AL_MAX = 5;
  localparam int unsigned CL_W   = 3;
  localparam int unsigned AL_W   = 3;

  typedef struct packed {
    logic [CL_W-1:0] cl;
    logic [AL_W-1:0] al;
    logic            bl8;
  } mode_t;

  localparam mode_t MODE_RESET = '{cl: 3'd3, al: 3'd0, bl8: 1'b0};
endpackage

// File: rtl/casw_mode_shadow.sv
module casw_mode_shadow
  import casw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cfg_we_i,
  input  mode_t cfg_mode_i,
  input  logic  idle_i,
  output mode_t act_o,
  output logic  pend_o
);
  mode_t act_q, pend_mode_q;
  logic  pend_q, legal;

  assign legal = (cfg_mode_i.cl >= CL_W'(CL_MIN)) && (cfg_mode_i.cl <= CL_W'(CL_MAX)) &&
                 (cfg_mode_i.al <= AL_W'(AL_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= MODE_RESET;
      pend_mode_q <= MODE_RESET;
      pend_q      <= 1'b0;
    end else if (cfg_we_i && legal) begin
      if (idle_i) begin
        act_q  <= cfg_mode_i;
        pend_q <= 1'b0;
      end else begin
        pend_mode_q <= cfg_mode_i;
        pend_q      <= 1'b1;
      end
    end else if (pend_q && idle_i) begin
      act_q  <= pend_mode_q;
      pend_q <= 1'b0;
    end
  end

  assign act_o  = act_q;
  assign pend_o = pend_q;

  assert_act_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.cl >= CL_W'(CL_MIN)) && (act_q.cl <= CL_W'(CL_MAX)) && (act_q.al <= AL_W'(AL_MAX)));

  assert_hold_in_flight_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(act_q));

  assert_pend_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && idle_i && !cfg_we_i) |=> !pend_q);
endmodule

// File: rtl/casw_lane.sv
module casw_lane #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned LAT_W = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic [CNT_W-1:0] burst_i,
  output logic             pre_o,
  output logic             win_o,
  output logic             post_o,
  output logic             busy_o
);
  logic [DEPTH-1:0] slot_q, slot_d;
  logic [CNT_W-1:0] cnt_q;
  logic             post_q;
  logic [LAT_W-1:0] idx;

  // token reaches slot 0 one cycle before the first data cycle
  assign idx = lat_i - LAT_W'(2);

  always_comb begin
    slot_d = slot_q >> 1;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (ins_i && (idx == LAT_W'(i))) slot_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      cnt_q  <= '0;
      post_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      if (slot_q[0])              cnt_q <= burst_i;
      else if (cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
      post_q <= (cnt_q == CNT_W'(1)) && !slot_q[0];
    end
  end

  assign pre_o  = slot_q[0] && (cnt_q == '0);
  assign win_o  = (cnt_q != '0);
  assign post_o = post_q;
  assign busy_o = (|slot_q) || win_o || post_q;

  assert_lat_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> (lat_i >= LAT_W'(2)) && (idx < LAT_W'(DEPTH)));

  assert_no_collide_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> ((slot_q >> 1) & (DEPTH'(1) << idx)) == '0);

  assert_pre_leads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_o |=> win_o);

  assert_pre_outside_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_o |-> !win_o);

  assert_post_trails_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_o |-> !win_o && $past(win_o));
endmodule

// File: rtl/casw_window_gen.sv
module casw_window_gen
  import casw_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [CL_W-1:0] cfg_cl_i,
  input  logic [AL_W-1:0] cfg_al_i,
  input  logic            cfg_bl8_i,
  input  logic            cmd_valid_i,
  input  logic            cmd_write_i,
  output logic            rd_pre_o,
  output logic            rd_win_o,
  output logic            rd_post_o,
  output logic            wr_pre_o,
  output logic            wr_win_o,
  output logic            wr_post_o,
  output logic            busy_o,
  output logic            cfg_pending_o
);
  localparam int unsigned MAX_RL = CL_MAX + AL_MAX;
  localparam int unsigned LAT_W  = $clog2(MAX_RL + 1);
  localparam int unsigned DEPTH  = MAX_RL - 1;

  mode_t            act;
  logic             idle;
  logic [LAT_W-1:0] rl, wl;
  logic [CNT_W-1:0] burst;
  logic [1:0]       pre, win, post, lbusy;

  casw_mode_shadow i_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_mode_i ('{cl: cfg_cl_i, al: cfg_al_i, bl8: cfg_bl8_i}),
    .idle_i     (idle),
    .act_o      (act),
    .pend_o     (cfg_pending_o)
  );

  assign rl    = LAT_W'(act.cl) + LAT_W'(act.al);
  assign wl    = rl - LAT_W'(1);
  assign burst = act.bl8 ? CNT_W'(4) : CNT_W'(2);

  // lane 0 = read, lane 1 = write
  for (genvar g = 0; g < 2; g++) begin : g_lane
    casw_lane #(.DEPTH(DEPTH), .LAT_W(LAT_W), .CNT_W(CNT_W)) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ins_i   (cmd_valid_i && (cmd_write_i == 1'(g))),
      .lat_i   ((g == 1) ? wl : rl),
      .burst_i (burst),
      .pre_o   (pre[g]),
      .win_o   (win[g]),
      .post_o  (post[g]),
      .busy_o  (lbusy[g])
    );
  end

  assign busy_o = |lbusy;
  assign idle   = !busy_o && !cmd_valid_i;

  assign rd_pre_o  = pre[0];
  assign rd_win_o  = win[0];
  assign rd_post_o = post[0];
  assign wr_pre_o  = pre[1];
  assign wr_win_o  = win[1];
  assign wr_post_o = post[1];

  assert_busy_after_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> busy_o);

  assert_win_needs_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_win_o || wr_win_o || rd_post_o || wr_post_o) |-> busy_o);
endmodule

// File: tb/test_casw_window_gen.sv
module test_casw_window_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic       cfg_we = 0, cfg_bl8 = 0, cmd_valid = 0, cmd_write = 0;
  logic [2:0] cfg_cl = 0, cfg_al = 0;
  logic rd_pre, rd_win, rd_post, wr_pre, wr_win, wr_post, busy, pending;

  casw_window_gen i_casw_window_gen (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_cl_i(cfg_cl), .cfg_al_i(cfg_al),
    .cfg_bl8_i(cfg_bl8), .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write),
    .rd_pre_o(rd_pre), .rd_win_o(rd_win), .rd_post_o(rd_post),
    .wr_pre_o(wr_pre), .wr_win_o(wr_win), .wr_post_o(wr_post),
    .busy_o(busy), .cfg_pending_o(pending)
  );

  localparam int NC = 6000;
  int unsigned n_chk = 0, n_bad = 0;
  int  cyc = 0;
  bit  done = 0;
  bit  m_rd [0:NC+40];
  bit  m_wr [0:NC+40];
  bit  m_busy [0:NC+40];
  int  a_cl = 3, a_al = 0;
  bit  a_bl8 = 0;
  bit  p_v = 0;
  int  p_cl = 3, p_al = 0;
  bit  p_bl8 = 0;
  int  last_rd = -100, last_wr = -100;

  task automatic chk(string what, string req, logic act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual=%b expected=%b", req, what, cyc, act, exp);
    end
  endtask

  function automatic bit pre_exp(bit m[0:NC+40], int c);
    return m[c+1] && !m[c];
  endfunction

  function automatic bit post_exp(bit m[0:NC+40], int c);
    return (c > 0) && m[c-1] && !m[c];
  endfunction

  task automatic step(bit cv, bit cw, bit we, int cl, int al, bit b8);
    int  b, lat;
    bit  idle, legal;
    @(negedge clk);
    chk("rd_win",  "R2",  rd_win,  m_rd[cyc]);
    chk("wr_win",  "R3",  wr_win,  m_wr[cyc]);
    chk("rd_pre",  "R5",  rd_pre,  pre_exp(m_rd, cyc));
    chk("wr_pre",  "R5",  wr_pre,  pre_exp(m_wr, cyc));
    chk("rd_post", "R6",  rd_post, post_exp(m_rd, cyc));
    chk("wr_post", "R6",  wr_post, post_exp(m_wr, cyc));
    chk("busy",    "R11", busy,    m_busy[cyc]);
    chk("pending", "R9",  pending, p_v);
    b = a_bl8 ? 4 : 2;
    if (cv && (cw ? (cyc - last_wr < b) : (cyc - last_rd < b))) cv = 0;
    cmd_valid = cv; cmd_write = cw; cfg_we = we;
    cfg_cl = 3'(cl); cfg_al = 3'(al); cfg_bl8 = b8;
    idle = !m_busy[cyc] && !cv;
    if (cv) begin
      lat = a_al + a_cl - (cw ? 1 : 0);
      for (int i = 0; i < b; i++) begin
        if (cw) m_wr[cyc+lat+i] = 1; else m_rd[cyc+lat+i] = 1;
      end
      for (int i = 1; i <= lat + b; i++) m_busy[cyc+i] = 1;
      if (cw) last_wr = cyc; else last_rd = cyc;
    end
    legal = (cl >= 3) && (cl <= 6) && (al <= 5);
    if (we && legal) begin
      if (idle) begin a_cl = cl; a_al = al; a_bl8 = b8; p_v = 0; end
      else begin p_v = 1; p_cl = cl; p_al = al; p_bl8 = b8; end
    end else if (p_v && idle) begin
      a_cl = p_cl; a_al = p_al; a_bl8 = p_bl8; p_v = 0;
    end
    cyc++;
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("rd_win reset", "R1", rd_win, 0);   chk("wr_win reset", "R1", wr_win, 0);
    chk("rd_pre reset", "R1", rd_pre, 0);   chk("wr_pre reset", "R1", wr_pre, 0);
    chk("rd_post reset", "R1", rd_post, 0); chk("wr_post reset", "R1", wr_post, 0);
    chk("busy reset", "R1", busy, 0);       chk("pending reset", "R1", pending, 0);
    rst_ni = 1'b1;

    // R1 defaults: RL=3, WL=2 (shortest), 2-cycle bursts
    step(1, 0, 0, 0, 0, 0); idle_n(8);
    step(1, 1, 0, 0, 0, 0); idle_n(8);
    // R7: gapless writes at WL=2 and reads
    step(1, 1, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0); idle_n(8);
    step(1, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0); idle_n(8);

    // R4: eight-beat bursts, CL5 AL2
    step(0, 0, 1, 5, 2, 1); step(1, 0, 0, 0, 0, 0); idle_n(14);
    // R7: merge at spacing 4; R10: spacing 6 with several in flight
    step(1, 0, 0, 0, 0, 0); idle_n(3); step(1, 0, 0, 0, 0, 0); idle_n(3); step(1, 0, 0, 0, 0, 0);
    idle_n(5); step(1, 0, 0, 0, 0, 0); idle_n(5); step(1, 1, 0, 0, 0, 0); idle_n(16);

    // R9: config while busy is held, commands use old settings
    step(1, 0, 0, 0, 0, 0); step(0, 0, 1, 3, 0, 0); step(1, 1, 0, 0, 0, 0);
    step(0, 0, 1, 4, 1, 0); idle_n(20);
    step(1, 0, 0, 0, 0, 0); idle_n(10);

    // R8: illegal fields are ignored (timing stays CL4 AL1)
    step(0, 0, 1, 2, 0, 1); step(0, 0, 1, 7, 1, 1); step(0, 0, 1, 5, 6, 1);
    step(1, 0, 0, 0, 0, 0); idle_n(10); step(1, 1, 0, 0, 0, 0); idle_n(10);

    // R2/R3 at the largest latency
    step(0, 0, 1, 6, 5, 1); step(1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0);
    idle_n(3); step(1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0); idle_n(20);

    // random mix, R2 R3 R7 R8 R9 R10 R11
    for (int blk = 0; blk < 60; blk++) begin
      int rate = $urandom_range(0, 2) * 30;
      for (int i = 0; i < 50; i++) begin
        bit cv = ($urandom_range(0, 99) < rate);
        bit cw = $urandom_range(0, 1);
        bit we = ($urandom_range(0, 99) < 4);
        step(cv, cw, we, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 1));
      end
    end
    idle_n(30);
    finish_run();
  end
endmodule